// File: doc/BRIEF.md
# Flash Ready-Wait Supervisor

This block waits for a flash device to finish an operation, such as a program, an erase or a reset, and reports how the wait ended. A one-cycle start pulse begins a wait. The wait checks readiness in one of two ways. The first way samples a ready/busy pin. The second way, used when no such pin is wired, repeatedly asks a byte-bus engine for the device status byte and tests its ready bit. A short rule applies in both modes: no readiness sample is taken until a fixed hold-off has passed since the start.

The timeout is set per wait in clock ticks. A value of zero selects a built-in default that depends on the mode. The pin-sampling default matches the program/erase budget, and the status-polling default matches the post-reset budget. When the budget runs out, the block checks readiness one more time. It raises its timeout flag only if the device is still busy at that last check.

Every wait ends with one more status read. The byte from that read is returned, together with an error flag that is set when its ready bit is clear. The status reads use a plain request/acknowledge handshake. The electrical timing of the flash bus is left to the engine on the other side of that handshake.

Top module: `nand_rdy_watch`

## Requirements
- R1: No readiness sample and no status request occurs within the first HOLDOFF_NS of a wait: ceil(CLK_HZ·HOLDOFF_NS/1e9) cycles, 5 cycles at 50 MHz and 100 ns. With the start pulse sampled at edge 0, the first pin sample is taken at edge 6, and in status mode the first request is launched at edge 6.
- R2: In pin mode (`use_status`=0), a high level on `rb_ready` means ready. The pin is sampled on every edge after the hold-off, and a ready sample ends the polling.
- R3: In status mode (`use_status`=1), status reads are issued back to back, one every 3 cycles. A read whose byte has bit 6 set means ready and ends the polling.
- R4: The budget `tmo_ticks` counts cycles from the start edge. The budget has run out at an evaluation edge when the number of cycles elapsed before that edge is at least `tmo_ticks`. A ready result at the same edge takes priority.
- R5: `tmo_ticks`=0 selects the default budget: DFLT_PIN_US microseconds in pin mode, or DFLT_STAT_US microseconds in status mode, converted to cycles with CLK_HZ. The shipped values are 400 ms and 250 ms.
- R6: When the budget runs out, readiness is checked exactly once more. In pin mode this is one extra pin sample on the next edge. In status mode it is one extra status read. `timed_out` is set only if this last check still shows busy.
- R7: Every wait ends with one final status read. `stat_byte` returns that byte, and `stat_err` is 1 exactly when its bit 6 is 0.
- R8: `done` is high for exactly one cycle per wait. `timed_out`, `stat_byte` and `stat_err` change only in that cycle and hold their values until the next completion.
- R9: A start pulse during a wait is ignored. The running wait keeps its timing and results, and no second completion follows.
- R10: `st_req` rises after a launch and stays high until `st_ack` is sampled high. `st_data` is captured at that same edge. In pin mode, `st_req` is high only for the final read.
- R11: Reset (synchronous, active low) clears `done`, `st_req`, `timed_out`, `stat_byte` and `stat_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start-wait pulse, ignored while busy |
| use_status | input | 1 | 0: sample ready pin; 1: poll the status byte |
| tmo_ticks | input | TMO_W | Budget in cycles; 0 selects the mode default |
| rb_ready | input | 1 | Ready/busy pin, high when ready (synchronous to clk) |
| st_req | output | 1 | Status-read request to the byte-bus engine |
| st_ack | input | 1 | Status-read acknowledge, one cycle |
| st_data | input | SB_W | Status byte, valid with st_ack |
| done | output | 1 | One-cycle completion pulse |
| timed_out | output | 1 | Budget ran out and the last check was busy |
| stat_byte | output | SB_W | Byte from the final status read |
| stat_err | output | 1 | Final status byte has its ready bit clear |

## Verification
The start pulse is sampled at edge 0, and H is the hold-off count. In pin mode, `done` is due at edge k+3 when a ready sample occurs at edge k, or at edge x+4 when the budget runs out at edge x. In status mode, poll j is evaluated at edge H+3+3j, and `done` is due 3 cycles after a ready poll or 6 cycles after the poll at which the budget runs out. The bench computes the due edge from these formulas before each wait. It then compares `done` (and, in pin mode, `st_req`) on the falling edge after every clock, so a completion that comes one cycle early or late is reported. The results are checked only in the cycle in which `done` is high.

// File: rtl/rdw_pkg.sv
// Shared types for the flash ready-wait supervisor.
// Assumes: nothing beyond the standard language.
package rdw_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,        // no wait in progress
        ST_HOLD,        // hold-off before the first sample
        ST_PIN_POLL,    // sampling the ready pin each cycle
        ST_PIN_LAST,    // single pin sample after the budget ran out
        ST_POLL_ISSUE,  // launch a polling status read
        ST_POLL_WAIT,   // wait for the polling status byte
        ST_LAST_ISSUE,  // launch the post-expiry status read
        ST_LAST_WAIT,   // wait for the post-expiry status byte
        ST_FIN_ISSUE,   // launch the final status read
        ST_FIN_WAIT     // wait for the final status byte
    } rdw_state_e;

endpackage

// File: rtl/rdw_ticker.sv
// Elapsed-cycle counter for one wait.
// Clears on the accepted start, counts every cycle while running,
// saturates at its maximum, and flags when the count reaches the limit.
// Assumes: clr and run are never both needed in one cycle beyond clr winning.
module rdw_ticker #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         run,
    input  logic [W-1:0] lim,
    output logic [W-1:0] count,
    output logic         expired
);
    localparam logic [W-1:0] CNT_MAX = '1;

    // Purpose: track cycles elapsed since the start edge.
    always_ff @(posedge clk) begin
        if (!rst_n)                          count <= '0;
        else if (clr)                        count <= '0;
        else if (run && (count != CNT_MAX))  count <= count + 1'b1;
    end

    // Purpose: compare the elapsed count with the latched budget.
    always_comb expired = (count >= lim);

endmodule

// File: rtl/rdw_status_port.sv
// Request/acknowledge port for reading the device status byte.
// A launch pulse raises the request; it drops at the edge that sees the
// acknowledge, where the byte is captured and a one-cycle got pulse follows.
// Assumes: the engine acknowledges each request with a single-cycle st_ack.
module rdw_status_port #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          launch,
    input  logic          st_ack,
    input  logic [DW-1:0] st_data,
    output logic          st_req,
    output logic          got,
    output logic [DW-1:0] val
);
    // Purpose: hold the request until it is acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n)                 st_req <= 1'b0;
        else if (launch)            st_req <= 1'b1;
        else if (st_req && st_ack)  st_req <= 1'b0;
    end

    // Purpose: capture the byte and flag its arrival for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            got <= 1'b0;
            val <= '0;
        end else begin
            got <= st_req && st_ack;
            if (st_req && st_ack) val <= st_data;
        end
    end

endmodule

// File: rtl/nand_rdy_watch.sv
// Flash ready-wait supervisor (top).
// Waits for a flash operation to finish by sampling a ready pin or by
// polling the status byte. A fixed hold-off comes first, the budget ends
// with one last check, and every wait closes with a final status read.
// Assumes: rb_ready is already synchronous to clk; the budget is given
// in clock cycles, and zero selects a per-mode default.
module nand_rdy_watch #(
    parameter int CLK_HZ       = 50_000_000,
    parameter int HOLDOFF_NS   = 100,
    parameter int DFLT_PIN_US  = 400_000,
    parameter int DFLT_STAT_US = 250_000,
    parameter int TMO_W        = 32,
    parameter int SB_W         = 8,
    parameter int RDY_BIT      = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            use_status,
    input  logic [TMO_W-1:0] tmo_ticks,
    input  logic            rb_ready,
    output logic            st_req,
    input  logic            st_ack,
    input  logic [SB_W-1:0] st_data,
    output logic            done,
    output logic            timed_out,
    output logic [SB_W-1:0] stat_byte,
    output logic            stat_err
);
    import rdw_pkg::*;

    localparam longint CYC_PER_US = longint'(CLK_HZ) / 64'd1_000_000;
    localparam longint HOLD_RAW   = (longint'(CLK_HZ) / 64'd1_000_000 * longint'(HOLDOFF_NS) + 64'd999) / 64'd1000;
    localparam longint HOLD_CYC   = (HOLD_RAW < 64'd1) ? 64'd1 : HOLD_RAW;
    localparam logic [TMO_W-1:0] HOLD_LAST = TMO_W'(HOLD_CYC - 64'd1);
    localparam logic [TMO_W-1:0] DFLT_PIN  = TMO_W'(CYC_PER_US * longint'(DFLT_PIN_US));
    localparam logic [TMO_W-1:0] DFLT_STAT = TMO_W'(CYC_PER_US * longint'(DFLT_STAT_US));

    rdw_state_e      st, nxt;
    logic            mode_q;
    logic [TMO_W-1:0] lim_q;
    logic            tmo_pend;
    logic            launch;
    logic            accept;
    logic            busy;
    logic            got;
    logic [SB_W-1:0] val;
    logic [TMO_W-1:0] elapsed;
    logic            expired;

    // Purpose: a start is taken only while idle.
    always_comb accept = (st == ST_IDLE) && start;
    // Purpose: a wait is in progress in every state but idle.
    always_comb busy   = (st != ST_IDLE);

    rdw_ticker #(.W(TMO_W)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (accept),
        .run     (busy),
        .lim     (lim_q),
        .count   (elapsed),
        .expired (expired)
    );

    rdw_status_port #(.DW(SB_W)) u_port (
        .clk     (clk),
        .rst_n   (rst_n),
        .launch  (launch),
        .st_ack  (st_ack),
        .st_data (st_data),
        .st_req  (st_req),
        .got     (got),
        .val     (val)
    );

    // Purpose: next-state and read-launch decode of the wait sequence.
    always_comb begin
        nxt    = st;
        launch = 1'b0;
        unique case (st)
            ST_IDLE:       if (start) nxt = ST_HOLD;
            ST_HOLD:       if (elapsed == HOLD_LAST)
                               nxt = mode_q ? ST_POLL_ISSUE : ST_PIN_POLL;
            ST_PIN_POLL:   if (rb_ready)     nxt = ST_FIN_ISSUE;
                           else if (expired) nxt = ST_PIN_LAST;
            ST_PIN_LAST:   nxt = ST_FIN_ISSUE;
            ST_POLL_ISSUE: begin launch = 1'b1; nxt = ST_POLL_WAIT; end
            ST_POLL_WAIT:  if (got) begin
                               if (val[RDY_BIT]) nxt = ST_FIN_ISSUE;
                               else if (expired) nxt = ST_LAST_ISSUE;
                               else              nxt = ST_POLL_ISSUE;
                           end
            ST_LAST_ISSUE: begin launch = 1'b1; nxt = ST_LAST_WAIT; end
            ST_LAST_WAIT:  if (got) nxt = ST_FIN_ISSUE;
            ST_FIN_ISSUE:  begin launch = 1'b1; nxt = ST_FIN_WAIT; end
            ST_FIN_WAIT:   if (got) nxt = ST_IDLE;
            default:       nxt = ST_IDLE;
        endcase
    end

    // Purpose: state register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // Purpose: latch mode and budget, record the last-check verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= 1'b0;
            lim_q    <= '0;
            tmo_pend <= 1'b0;
        end else begin
            if (accept) begin
                mode_q   <= use_status;
                lim_q    <= (tmo_ticks != '0) ? tmo_ticks
                          : (use_status ? DFLT_STAT : DFLT_PIN);
                tmo_pend <= 1'b0;
            end
            if (st == ST_PIN_LAST)        tmo_pend <= !rb_ready;
            if (st == ST_LAST_WAIT && got) tmo_pend <= !val[RDY_BIT];
        end
    end

    // Purpose: publish results and the completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done      <= 1'b0;
            timed_out <= 1'b0;
            stat_byte <= '0;
            stat_err  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (st == ST_FIN_WAIT && got) begin
                done      <= 1'b1;
                timed_out <= tmo_pend;
                stat_byte <= val;
                stat_err  <= !val[RDY_BIT];
            end
        end
    end

endmodule

// File: rtl/nand_rdy_watch_chk.sv
// Property checker for the ready-wait supervisor, bound to the top.
// Assumes: the hold-off parameters match the bound instance.
module nand_rdy_watch_chk #(
    parameter int CLK_HZ     = 50_000_000,
    parameter int HOLDOFF_NS = 100,
    parameter int SB_W       = 8,
    parameter int RDY_BIT    = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic            busy,
    input logic            st_req,
    input logic            st_ack,
    input logic            done,
    input logic            timed_out,
    input logic [SB_W-1:0] stat_byte,
    input logic            stat_err
);
    localparam int HOLD_RAW = (CLK_HZ / 1_000_000 * HOLDOFF_NS + 999) / 1000;
    localparam int HOLD_CYC = (HOLD_RAW < 1) ? 1 : HOLD_RAW;

    logic [15:0] since;

    // Purpose: count cycles since the accepted start, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                     since <= '0;
        else if (start && !busy)        since <= '0;
        else if (busy && since != 16'hFFFF) since <= since + 16'd1;
    end

    // R1: no status request before the hold-off has elapsed
    a_r1_holdoff: assert property (@(posedge clk) disable iff (!rst_n)
        st_req |-> (busy && since >= 16'(HOLD_CYC)));

    // R8: completion is a single-cycle pulse
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: results move only with the completion pulse
    a_r8_results_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(timed_out) && $stable(stat_byte) && $stable(stat_err)));

    // R7: error flag agrees with the returned byte
    a_r7_err_matches: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (stat_err == !stat_byte[RDY_BIT]));

    // R10: a request is held until acknowledged
    a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_req && !st_ack) |=> st_req);

endmodule

bind nand_rdy_watch nand_rdy_watch_chk #(
    .CLK_HZ(CLK_HZ), .HOLDOFF_NS(HOLDOFF_NS), .SB_W(SB_W), .RDY_BIT(RDY_BIT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .st_req    (st_req),
    .st_ack    (st_ack),
    .done      (done),
    .timed_out (timed_out),
    .stat_byte (stat_byte),
    .stat_err  (stat_err)
);

// File: tb/tb_nand_rdy_watch.sv
module tb_nand_rdy_watch;
    localparam int H       = 5;      // 100 ns at 20 ns per cycle
    localparam int DEF_PIN = 1000;   // 20 us at 50 MHz
    localparam int DEF_ST  = 500;    // 10 us at 50 MHz
    localparam int NEVER   = 1_000_000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        use_status = 1'b0;
    logic [31:0] tmo_ticks = '0;
    logic        rb_ready = 1'b0;
    logic        st_req;
    logic        st_ack = 1'b0;
    logic [7:0]  st_data = '0;
    logic        done, timed_out, stat_err;
    logic [7:0]  stat_byte;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int nrdy_g = 0;
    int idx_g = 0;

    always #10 clk = ~clk;

    nand_rdy_watch #(.DFLT_PIN_US(20), .DFLT_STAT_US(10)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .use_status(use_status),
        .tmo_ticks(tmo_ticks), .rb_ready(rb_ready), .st_req(st_req),
        .st_ack(st_ack), .st_data(st_data), .done(done),
        .timed_out(timed_out), .stat_byte(stat_byte), .stat_err(stat_err)
    );

    function automatic logic [7:0] dev_byte(input int i, input int nr);
        return 8'h80 | ((i >= nr) ? 8'h40 : 8'h00) | 8'(i & 63);
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // status-byte engine: acknowledge one cycle after the request is seen
    always @(negedge clk) begin
        cyc++;
        if (st_ack) st_ack = 1'b0;
        else if (st_req) begin
            st_ack  = 1'b1;
            st_data = dev_byte(idx_g, nrdy_g);
            idx_g++;
        end
    end

    // watchdog
    initial begin
        wait (cyc > 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // One wait: compute the due edge and results, then compare every clock.
    task automatic run_op(input string tag, input bit smode, input int lim,
                          input int rdy_edge, input int nrdy, input int dup_k);
        int eff, de, fidx, j, e, kr, kx;
        bit etmo;
        logic [7:0] ebyte;
        eff = (lim == 0) ? (smode ? DEF_ST : DEF_PIN) : lim;
        if (!smode) begin
            kr = max2(H + 1, rdy_edge);
            kx = max2(H + 1, eff + 1);
            if (kr <= kx) begin de = kr + 3; etmo = 1'b0; end
            else begin de = kx + 4; etmo = !(kx + 1 >= rdy_edge); end
            fidx = 0;
        end else begin
            j = 0;
            forever begin
                e = H + 3 + 3 * j;
                if (j >= nrdy) begin de = e + 3; etmo = 1'b0; fidx = j + 1; break; end
                if (e - 1 >= eff) begin de = e + 6; etmo = !(j + 1 >= nrdy); fidx = j + 2; break; end
                j++;
            end
        end
        ebyte = dev_byte(fidx, nrdy);
        nrdy_g = nrdy;
        idx_g = 0;
        @(negedge clk);
        use_status = smode;
        tmo_ticks = lim;
        start = 1'b1;
        rb_ready = (0 >= rdy_edge);
        for (int k = 0; k <= de + 2; k++) begin
            @(negedge clk);
            start = (k + 1 == dup_k);
            chk({tag, " done timing"}, done, (k == de));
            if (!smode) chk("R10 pin-mode request only for final read", st_req, (k == de - 2));
            if (k == de) begin
                chk({tag, " R6 timed_out"}, timed_out, etmo);
                chk({tag, " R7 stat_byte"}, stat_byte, ebyte);
                chk({tag, " R7 stat_err"}, stat_err, !ebyte[6]);
            end
            rb_ready = ((k + 1) >= rdy_edge);
        end
        start = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 done", done, 0);
        chk("R11 st_req", st_req, 0);
        chk("R11 timed_out", timed_out, 0);
        chk("R11 stat_byte", stat_byte, 0);
        chk("R11 stat_err", stat_err, 0);
        @(negedge clk);
        rst_n = 1'b1;

        run_op("R2 pin ready", 0, 100, 12, 0, -1);
        run_op("R1 pin ready at start waits hold-off", 0, 100, 0, 0, -1);
        run_op("R4 pin budget expiry", 0, 30, NEVER, 0, -1);
        run_op("R6 pin ready on last check", 0, 30, 32, 0, -1);
        run_op("R7 pin final status busy", 0, 100, 10, 5, -1);
        run_op("R3 status ready", 1, 200, NEVER, 2, -1);
        run_op("R4 status budget expiry", 1, 20, NEVER, 100, -1);
        run_op("R6 status ready on last read", 1, 20, NEVER, 6, -1);
        run_op("R5 pin default budget", 0, 0, NEVER, 0, -1);
        run_op("R5 status default budget", 1, 0, NEVER, 1000, -1);
        run_op("R9 start while busy ignored", 0, 100, 12, 0, 8);
        run_op("R8 back-to-back wait", 1, 200, NEVER, 0, -1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule